// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block sits between a host and a three-wire serial EEPROM of the 93-series family. The host gives one request at a time on a valid/ready interface. A request names one of five operations: read word, write word, write-enable, write-disable or erase all. The block turns each request into one or more chip-select frames. Each frame holds a start bit, a two-bit opcode, an address field of variable length and, for data operations, the data bits. The shift clock is made by dividing the system clock. The block answers with a one-cycle response that carries the read word or an error flag.

Four configuration inputs describe the device. They give the size (128, 256 or 512 bytes), the word width (8 or 16 bits) and two optional padding rules that some parts need. These inputs are latched when a request is accepted. A write request is wrapped by the block itself: an enable frame first, then the write frame, then a disable frame. After every frame, chip select stays low for a minimum time. This time is the long program wait after a write or an erase-all frame, and the short deselect gap after any other frame.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: During and after a synchronous reset, `ee_cs`, `ee_sk`, `ee_di`, `resp_valid` and `resp_err` are 0 and `req_ready` is 1.
- R2: Every frame begins with a 1 bit followed by a two-bit opcode, sent MSB first: read sends 1,1,0; write sends 1,0,1; the special commands (enable, disable, erase all) send 1,0,0.
- R3: The address field follows the opcode, MSB first. It is 7, 8 or 9 bits wide for `cfg_size` 0, 1 or 2 when `cfg_wide`=0, and one bit narrower when `cfg_wide`=1. It carries the byte offset in 8-bit mode and the offset shifted right by one in 16-bit mode. `cfg_size` 3 acts as 2.
- R4: A special command places a two-bit code in the two most significant address bits (11 enable, 10 erase all, 00 disable), and the remaining address bits are 0.
- R5: With `cfg_spec_pad`=1, special-command frames carry two extra 0 bits after the address field. Read and write frames are unchanged.
- R6: With `cfg_read_pad`=1, read frames carry one extra 0 clock after the address field, before the data clocks.
- R7: A read clocks 8 (8-bit mode) or 16 (16-bit mode) data bits. `ee_do` is sampled on each rising `ee_sk` edge after the command bits, and the data is assembled MSB first into `resp_rdata`. In 8-bit mode bits 15:8 of `resp_rdata` are 0.
- R8: A write request (`req_cmd`=1) produces exactly three frames: enable, write, disable. The write frame appends the low 8 bits or all 16 bits of `req_wdata`, MSB first. Host codes 2, 3 and 4 each produce one frame (enable, disable, erase all), and code 0 produces one read frame.
- R9: Before chip select rises again, it stays low for at least `PROG_CYC` cycles after a write or erase-all frame and for at least `GAP_CYC` cycles after any other frame.
- R10: A read or write whose offset is at or above the device size in bytes, or any `req_cmd` above 4, is rejected. The response arrives in the cycle after acceptance with `resp_err`=1, and no chip-select activity takes place.
- R11: `ee_sk` is low whenever `ee_cs` is low. `ee_di` changes only on falling `ee_sk` edges.
- R12: `req_ready` is low from the acceptance of a request that is carried out until its response. `resp_valid` is a single-cycle pulse, and `req_ready` is 1 in that cycle.
- R13: In 16-bit mode, bit 0 of the offset is ignored, so writing at offset 2k+1 updates the same word that a read at offset 2k returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 2 | Device size code: 0=128, 1=256, 2=512 bytes |
| cfg_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| cfg_spec_pad | input | 1 | Two extra trailing bits on special commands |
| cfg_read_pad | input | 1 | One extra dummy clock on reads |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_cmd | input | 3 | 0 read, 1 write, 2 enable, 3 disable, 4 erase all |
| req_off | input | 10 | Byte offset |
| req_wdata | input | 16 | Write data |
| resp_valid | output | 1 | Response pulse |
| resp_err | output | 1 | Request rejected |
| resp_rdata | output | 16 | Read data |
| ee_cs | output | 1 | Chip select, active high |
| ee_sk | output | 1 | Shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
A rejected request must show its response in the first cycle after the acceptance edge. The bench samples at the next falling clock edge and requires a zero wait count there. An accepted request answers only after its last frame and the gap that follows, so the bench waits falling edge by falling edge for the pulse. During that wait it requires `req_ready` to stay low. A behavioural EEPROM in the bench captures every frame bit on rising `ee_sk` and returns read data on falling edges. At each chip-select rise it counts the low cycles and compares them with the minimum that the previous frame type requires. Each captured frame is compared bit for bit with a frame built from the requirements.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int OFF_W   = 10;
  localparam int WORD_W  = 16;
  localparam int FRAME_W = 32;
  localparam int LEN_W   = 6;

  typedef enum logic [2:0] {
    HC_READ  = 3'd0,
    HC_WRITE = 3'd1,
    HC_WREN  = 3'd2,
    HC_WRDIS = 3'd3,
    HC_ERASE = 3'd4
  } host_cmd_e;

  typedef enum logic [2:0] {
    FK_READ,
    FK_WRITE,
    FK_EWEN,
    FK_EWDS,
    FK_ERAL
  } frame_kind_e;

  function automatic int sat_size(input logic [1:0] sz);
    return (sz == 2'd3) ? 2 : int'(sz);
  endfunction

  function automatic int addr_len(input logic [1:0] sz, input logic wide);
    return 7 + sat_size(sz) - (wide ? 1 : 0);
  endfunction

  function automatic logic [OFF_W:0] size_bytes(input logic [1:0] sz);
    return (OFF_W+1)'(128) << sat_size(sz);
  endfunction
endpackage

// File: rtl/mw_cmd_fmt.sv
module mw_cmd_fmt
  import mw_pkg::*;
(
  input  frame_kind_e        kind,
  input  logic [OFF_W-1:0]   off,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [1:0]         cfg_size,
  input  logic               cfg_wide,
  input  logic               cfg_spec_pad,
  input  logic               cfg_read_pad,
  output logic [FRAME_W-1:0] tx,
  output logic [LEN_W-1:0]   nbits
);
  int                 alen;
  int                 dlen;
  int                 pad;
  int                 total;
  logic               is_spec;
  logic [2:0]         opc;
  logic [1:0]         code;
  logic [OFF_W-1:0]   waddr;
  logic [WORD_W-1:0]  afield;
  logic [WORD_W-1:0]  cmd;
  logic [FRAME_W-1:0] payload;
  logic [FRAME_W-1:0] body;

  always_comb begin
    alen    = addr_len(cfg_size, cfg_wide);
    is_spec = (kind == FK_EWEN) || (kind == FK_EWDS) || (kind == FK_ERAL);
    dlen    = ((kind == FK_READ) || (kind == FK_WRITE)) ? (cfg_wide ? 16 : 8) : 0;
    case (kind)
      FK_READ:  opc = 3'b110;
      FK_WRITE: opc = 3'b101;
      default:  opc = 3'b100;
    endcase
    case (kind)
      FK_EWEN: code = 2'b11;
      FK_ERAL: code = 2'b10;
      default: code = 2'b00;
    endcase
    waddr = cfg_wide ? {1'b0, off[OFF_W-1:1]} : off;
    if (is_spec)
      afield = WORD_W'(code) << (alen - 2);
    else
      afield = WORD_W'(waddr) & ((WORD_W'(1) << alen) - WORD_W'(1));
    if (is_spec && cfg_spec_pad)
      pad = 2;
    else if ((kind == FK_READ) && cfg_read_pad)
      pad = 1;
    else
      pad = 0;
    cmd     = ((WORD_W'(opc) << alen) | afield) << pad;
    payload = (kind == FK_WRITE) ?
              (FRAME_W'(wdata) & ((FRAME_W'(1) << dlen) - FRAME_W'(1))) : '0;
    body    = (FRAME_W'(cmd) << dlen) | payload;
    total   = 3 + alen + pad + dlen;
    nbits   = LEN_W'(total);
    tx      = body << (FRAME_W - total);
  end
endmodule

// File: rtl/mw_shift_eng.sv
module mw_shift_eng
  import mw_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx,
  input  logic [LEN_W-1:0]   nbits,
  input  logic               ee_do,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  output logic               done,
  output logic [WORD_W-1:0]  rx
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eng_st_e;

  eng_st_e            st;
  logic [FRAME_W-1:0] sreg;
  logic [LEN_W-1:0]   cnt;
  logic [DIV_W-1:0]   div;

  assign rx = sreg[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= E_IDLE;
      sreg  <= '0;
      cnt   <= '0;
      div   <= '0;
      ee_cs <= 1'b0;
      ee_sk <= 1'b0;
      ee_di <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (start) begin
            sreg  <= tx;
            cnt   <= nbits;
            div   <= '0;
            ee_cs <= 1'b1;
            ee_sk <= 1'b0;
            ee_di <= tx[FRAME_W-1];
            st    <= E_LOW;
          end
        end
        E_LOW: begin
          if (div == DIV_LAST) begin
            div   <= '0;
            ee_sk <= 1'b1;
            sreg  <= {sreg[FRAME_W-2:0], ee_do};
            st    <= E_HIGH;
          end else begin
            div <= div + DIV_W'(1);
          end
        end
        E_HIGH: begin
          if (div == DIV_LAST) begin
            div   <= '0;
            ee_sk <= 1'b0;
            if (cnt == LEN_W'(1)) begin
              ee_cs <= 1'b0;
              ee_di <= 1'b0;
              done  <= 1'b1;
              st    <= E_IDLE;
            end else begin
              cnt   <= cnt - LEN_W'(1);
              ee_di <= sreg[FRAME_W-1];
              st    <= E_LOW;
            end
          end else begin
            div <= div + DIV_W'(1);
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk); // R11
  AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R11
  AST_DONE_DESELECTS: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ee_cs && !ee_sk)); // R9
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int PROG_CYC = 600000,
  parameter int GAP_CYC  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_wide,
  input  logic              cfg_spec_pad,
  input  logic              cfg_read_pad,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [WORD_W-1:0] resp_rdata,
  output frame_kind_e       cur_kind,
  output logic [OFF_W-1:0]  cur_off,
  output logic [WORD_W-1:0] cur_wdata,
  output logic [1:0]        cur_size,
  output logic              cur_wide,
  output logic              cur_spec_pad,
  output logic              cur_read_pad,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic [WORD_W-1:0] eng_rx,
  input  logic              eng_cs
);
  localparam int MAX_WAIT = (PROG_CYC > GAP_CYC) ? PROG_CYC : GAP_CYC;
  localparam int TIM_W    = $clog2(MAX_WAIT + 2);

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_XFER, S_GAP} seq_st_e;

  seq_st_e          st;
  host_cmd_e        op_q;
  logic [1:0]       step;
  logic             last_step;
  logic             long_wait;
  logic [TIM_W-1:0] timer;
  logic             accept;
  logic             bad_req;

  assign accept  = req_valid && req_ready;
  assign bad_req = (req_cmd > 3'd4) ||
                   (((req_cmd == 3'd0) || (req_cmd == 3'd1)) &&
                    ({1'b0, req_off} >= size_bytes(cfg_size)));

  always_comb begin
    cur_kind  = FK_READ;
    last_step = 1'b1;
    case (op_q)
      HC_WRITE: begin
        last_step = (step == 2'd2);
        case (step)
          2'd0:    cur_kind = FK_EWEN;
          2'd1:    cur_kind = FK_WRITE;
          default: cur_kind = FK_EWDS;
        endcase
      end
      HC_WREN:  cur_kind = FK_EWEN;
      HC_WRDIS: cur_kind = FK_EWDS;
      HC_ERASE: cur_kind = FK_ERAL;
      default:  cur_kind = FK_READ;
    endcase
    long_wait = (cur_kind == FK_WRITE) || (cur_kind == FK_ERAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      op_q         <= HC_READ;
      step         <= '0;
      timer        <= '0;
      req_ready    <= 1'b1;
      resp_valid   <= 1'b0;
      resp_err     <= 1'b0;
      resp_rdata   <= '0;
      eng_start    <= 1'b0;
      cur_off      <= '0;
      cur_wdata    <= '0;
      cur_size     <= '0;
      cur_wide     <= 1'b0;
      cur_spec_pad <= 1'b0;
      cur_read_pad <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      eng_start  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (bad_req) begin
              resp_valid <= 1'b1;
              resp_err   <= 1'b1;
            end else begin
              op_q         <= host_cmd_e'(req_cmd);
              cur_off      <= req_off;
              cur_wdata    <= req_wdata;
              cur_size     <= cfg_size;
              cur_wide     <= cfg_wide;
              cur_spec_pad <= cfg_spec_pad;
              cur_read_pad <= cfg_read_pad;
              step         <= '0;
              req_ready    <= 1'b0;
              st           <= S_LAUNCH;
            end
          end
        end
        S_LAUNCH: begin
          eng_start <= 1'b1;
          st        <= S_XFER;
        end
        S_XFER: begin
          if (eng_done) begin
            if (cur_kind == FK_READ)
              resp_rdata <= cur_wide ? eng_rx : {8'h00, eng_rx[7:0]};
            timer <= long_wait ? TIM_W'(PROG_CYC) : TIM_W'(GAP_CYC);
            st    <= S_GAP;
          end
        end
        S_GAP: begin
          if (timer <= TIM_W'(1)) begin
            if (last_step) begin
              resp_valid <= 1'b1;
              resp_err   <= 1'b0;
              req_ready  <= 1'b1;
              st         <= S_IDLE;
            end else begin
              step <= step + 2'd1;
              st   <= S_LAUNCH;
            end
          end else begin
            timer <= timer - TIM_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Independent watch of the deselect time, used only by the checks below.
  logic [TIM_W-1:0] low_cnt;
  logic [TIM_W-1:0] low_need;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= TIM_W'(MAX_WAIT);
      low_need <= '0;
    end else if (eng_done) begin
      low_cnt  <= '0;
      low_need <= long_wait ? TIM_W'(PROG_CYC) : TIM_W'(GAP_CYC);
    end else if (low_cnt < TIM_W'(MAX_WAIT)) begin
      low_cnt <= low_cnt + TIM_W'(1);
    end
  end

  AST_GAP_HONOURED: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> (low_cnt >= low_need)); // R9
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_err) |-> !eng_cs); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    eng_cs |-> !req_ready); // R12
  AST_RESP_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready); // R12
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int PROG_CYC = 600000,
  parameter int GAP_CYC  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_wide,
  input  logic              cfg_spec_pad,
  input  logic              cfg_read_pad,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [WORD_W-1:0] resp_rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  frame_kind_e        cur_kind;
  logic [OFF_W-1:0]   cur_off;
  logic [WORD_W-1:0]  cur_wdata;
  logic [1:0]         cur_size;
  logic               cur_wide;
  logic               cur_spec_pad;
  logic               cur_read_pad;
  logic               eng_start;
  logic               eng_done;
  logic [WORD_W-1:0]  eng_rx;
  logic [FRAME_W-1:0] tx;
  logic [LEN_W-1:0]   nbits;

  mw_seq #(
    .PROG_CYC (PROG_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_cmd      (req_cmd),
    .req_off      (req_off),
    .req_wdata    (req_wdata),
    .cfg_size     (cfg_size),
    .cfg_wide     (cfg_wide),
    .cfg_spec_pad (cfg_spec_pad),
    .cfg_read_pad (cfg_read_pad),
    .resp_valid   (resp_valid),
    .resp_err     (resp_err),
    .resp_rdata   (resp_rdata),
    .cur_kind     (cur_kind),
    .cur_off      (cur_off),
    .cur_wdata    (cur_wdata),
    .cur_size     (cur_size),
    .cur_wide     (cur_wide),
    .cur_spec_pad (cur_spec_pad),
    .cur_read_pad (cur_read_pad),
    .eng_start    (eng_start),
    .eng_done     (eng_done),
    .eng_rx       (eng_rx),
    .eng_cs       (ee_cs)
  );

  mw_cmd_fmt u_fmt (
    .kind         (cur_kind),
    .off          (cur_off),
    .wdata        (cur_wdata),
    .cfg_size     (cur_size),
    .cfg_wide     (cur_wide),
    .cfg_spec_pad (cur_spec_pad),
    .cfg_read_pad (cur_read_pad),
    .tx           (tx),
    .nbits        (nbits)
  );

  mw_shift_eng #(
    .HALF_CYC (HALF_CYC)
  ) u_eng (
    .clk   (clk),
    .rst   (rst),
    .start (eng_start),
    .tx    (tx),
    .nbits (nbits),
    .ee_do (ee_do),
    .ee_cs (ee_cs),
    .ee_sk (ee_sk),
    .ee_di (ee_di),
    .done  (eng_done),
    .rx    (eng_rx)
  );

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !ee_cs); // R9
endmodule

// File: tb/test_mw_eeprom_ctrl.sv
module test_mw_eeprom_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int PROG = 300;
  localparam int GAP  = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_size = 2'd0;
  logic cfg_wide = 1'b0, cfg_spec_pad = 1'b0, cfg_read_pad = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_cmd = 3'd0;
  logic [9:0] req_off = '0;
  logic [15:0] req_wdata = '0;
  logic resp_valid, resp_err;
  logic [15:0] resp_rdata;
  logic ee_cs, ee_sk, ee_di;
  logic ee_do = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mw_eeprom_ctrl #(.HALF_CYC(HALF), .PROG_CYC(PROG), .GAP_CYC(GAP)) i_mw_eeprom_ctrl (
    .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_wide(cfg_wide),
    .cfg_spec_pad(cfg_spec_pad), .cfg_read_pad(cfg_read_pad),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_off(req_off), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_err(resp_err), .resp_rdata(resp_rdata), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int alen_f();
    return 7 + int'(cfg_size) - (cfg_wide ? 1 : 0);
  endfunction
  function automatic int dlen_f();
    return cfg_wide ? 16 : 8;
  endfunction
  function automatic int dmask_f();
    return cfg_wide ? 32'hFFFF : 32'hFF;
  endfunction

  // expected frame, right aligned, built from R2..R8
  task automatic exp_frame(input int kind, input int off, input int wd,
                           output logic [63:0] b, output int len);
    int a, d, pad;
    logic [63:0] opc, af, cmd;
    a = alen_f(); d = 0; pad = 0;
    case (kind)
      0: begin opc = 64'b110; d = dlen_f(); pad = cfg_read_pad ? 1 : 0;
               af = 64'(cfg_wide ? (off >> 1) : off) & ((64'd1 << a) - 1); end
      1: begin opc = 64'b101; d = dlen_f();
               af = 64'(cfg_wide ? (off >> 1) : off) & ((64'd1 << a) - 1); end
      2: begin opc = 64'b100; af = 64'b11 << (a - 2); pad = cfg_spec_pad ? 2 : 0; end
      3: begin opc = 64'b100; af = 64'b00; pad = cfg_spec_pad ? 2 : 0; end
      default: begin opc = 64'b100; af = 64'b10 << (a - 2); pad = cfg_spec_pad ? 2 : 0; end
    endcase
    cmd = ((opc << a) | af) << pad;
    b = (cmd << d) | ((kind == 1) ? (64'(wd) & 64'(dmask_f())) : 64'd0);
    len = 3 + a + pad + d;
  endtask

  // behavioural EEPROM
  logic [63:0] fbits;
  int fcnt = 0;
  logic [63:0] log_bits [0:7];
  int log_len [0:7];
  int nlog = 0;
  logic [15:0] dev_mem [0:511];
  bit dev_wen = 0;
  logic [15:0] rd_sh;
  bit rd_active = 0;
  bit prev_long = 0;
  bit have_prev = 0;
  longint low_start = 0;
  int sk_bad = 0;

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      int l;
      fbits = {fbits[62:0], ee_di};
      fcnt++;
      l = 3 + alen_f() + (cfg_read_pad ? 1 : 0);
      if (fcnt == l && fbits[l-1 -: 3] == 3'b110) begin
        int ad;
        ad = int'((fbits >> (cfg_read_pad ? 1 : 0)) & ((64'd1 << alen_f()) - 1));
        rd_sh = cfg_wide ? dev_mem[ad] : {dev_mem[ad][7:0], 8'h00};
        rd_active = 1;
      end
    end
  end

  always @(negedge ee_sk) begin
    if (ee_cs && rd_active) begin
      ee_do = rd_sh[15];
      rd_sh = rd_sh << 1;
    end
  end

  always @(posedge ee_cs) begin
    if (have_prev)
      chk((cyc - low_start) >= (prev_long ? PROG : GAP), "R9 deselect time",
          cyc - low_start, prev_long ? PROG : GAP);
    fbits = '0; fcnt = 0; rd_active = 0; ee_do = 1'b0;
  end

  always @(negedge ee_cs) begin
    logic [2:0] opc;
    int d, ad;
    if (nlog < 8) begin log_bits[nlog] = fbits; log_len[nlog] = fcnt; end
    nlog++;
    opc = (fcnt >= 3) ? fbits[fcnt-1 -: 3] : 3'b000;
    prev_long = 0;
    d = dlen_f();
    if (opc == 3'b101) begin
      ad = int'((fbits >> d) & ((64'd1 << alen_f()) - 1));
      if (dev_wen) dev_mem[ad] = 16'(fbits & 64'(dmask_f()));
      prev_long = 1;
    end else if (opc == 3'b100 && fcnt >= 5) begin
      case (fbits[fcnt-4 -: 2])
        2'b11: dev_wen = 1;
        2'b00: dev_wen = 0;
        2'b10: begin
          if (dev_wen) for (int i = 0; i < 512; i++) dev_mem[i] = 16'(dmask_f());
          prev_long = 1;
        end
        default: ;
      endcase
    end
    have_prev = 1;
    low_start = cyc;
  end

  always @(negedge clk) if (!rst && !ee_cs && ee_sk) sk_bad++;

  logic [15:0] exp_mem [0:511];

  task automatic do_req(input int cmd, input int off, input int wd,
                        output logic [15:0] rd, output logic er, output int lat);
    bit bad_ready;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nlog = 0;
    req_valid = 1'b1; req_cmd = cmd[2:0]; req_off = off[9:0]; req_wdata = wd[15:0];
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; bad_ready = 0;
    while (!resp_valid && lat < 20000) begin
      if (req_ready) bad_ready = 1;
      @(negedge clk);
      lat++;
    end
    rd = resp_rdata; er = resp_err;
    chk(resp_valid && req_ready && !bad_ready, "R12 handshake", {resp_valid, req_ready, bad_ready}, 3'b110);
  endtask

  task automatic chk_frames(input int n, input int k0, input int k1, input int k2,
                            input int off, input int wd, input string tag);
    int ks [3];
    bit ok;
    logic [63:0] b;
    int len;
    ks[0] = k0; ks[1] = k1; ks[2] = k2;
    ok = (nlog == n);
    for (int i = 0; i < n && i < 3; i++) begin
      exp_frame(ks[i], off, wd, b, len);
      if (log_bits[i] != b || log_len[i] != len) begin
        ok = 0;
        $display("FAIL %s frame %0d actual=%0h/%0d expected=%0h/%0d", tag, i,
                 log_bits[i], log_len[i], b, len);
      end
    end
    if (nlog != n) $display("FAIL %s frame count actual=%0d expected=%0d", tag, nlog, n);
    n_chk++;
    if (!ok) n_fail++;
  endtask

  task automatic run_cfg(input int sz, input bit wide, input bit sp, input bit rp);
    logic [15:0] rd;
    logic er;
    int lat, size, off, wd, wa;
    int offs [8];
    @(negedge clk);
    cfg_size = sz[1:0]; cfg_wide = wide; cfg_spec_pad = sp; cfg_read_pad = rp;
    size = 128 << sz;
    do_req(2, 0, 0, rd, er, lat); chk_frames(1, 2, 0, 0, 0, 0, "R4 R5 enable frame");
    do_req(4, 0, 0, rd, er, lat); chk_frames(1, 4, 0, 0, 0, 0, "R4 R5 erase-all frame");
    do_req(3, 0, 0, rd, er, lat); chk_frames(1, 3, 0, 0, 0, 0, "R4 R5 disable frame");
    for (int i = 0; i < 512; i++) exp_mem[i] = 16'(dmask_f());
    off = int'($urandom % size);
    do_req(0, off, 0, rd, er, lat);
    chk_frames(1, 0, 0, 0, off, 0, "R2 R3 R6 read frame");
    chk(rd == 16'(dmask_f()) && !er, "R7 read after erase", rd, dmask_f());
    for (int i = 0; i < 8; i++) begin
      off = int'($urandom % size);
      if (i == 0) off = size - 1;
      if (i == 1) off = 0;
      wd = int'($urandom & 32'hFFFF);
      offs[i] = off;
      do_req(1, off, wd, rd, er, lat);
      chk_frames(3, 2, 1, 3, off, wd, "R2 R3 R8 write sequence");
      chk(!er && lat >= PROG, "R9 R8 write response", lat, PROG);
      wa = wide ? (off >> 1) : off;
      exp_mem[wa] = 16'(wd & dmask_f());
    end
    for (int i = 7; i >= 0; i--) begin
      do_req(0, offs[i], 0, rd, er, lat);
      wa = wide ? (offs[i] >> 1) : offs[i];
      chk(rd == exp_mem[wa] && !er, "R7 R3 read back", rd, exp_mem[wa]);
    end
    do_req(0, size, 0, rd, er, lat);
    chk(er && lat == 0 && nlog == 0, "R10 read beyond size", {er, 7'(lat), 8'(nlog)}, 16'h8000);
    do_req(1, 1023, 16'h1234, rd, er, lat);
    chk(er && lat == 0 && nlog == 0, "R10 write beyond size", {er, 7'(lat), 8'(nlog)}, 16'h8000);
    do_req(7, 0, 0, rd, er, lat);
    repeat (5) @(negedge clk);
    chk(er && lat == 0 && nlog == 0, "R10 unknown command", {er, 7'(lat), 8'(nlog)}, 16'h8000);
    if (wide) begin
      off = 2 * int'($urandom % (size / 2));
      wd = int'($urandom & 32'hFFFF);
      do_req(1, off + 1, wd, rd, er, lat);
      do_req(0, off, 0, rd, er, lat);
      chk(rd == 16'(wd), "R13 odd offset bit ignored", rd, wd);
      exp_mem[off >> 1] = 16'(wd);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) dev_mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di && !resp_valid && req_ready, "R1 in reset",
        {ee_cs, ee_sk, ee_di, resp_valid, req_ready}, 5'b00001);
    rst = 1'b0;
    @(negedge clk);
    chk(!ee_cs && !ee_sk && !resp_valid && !resp_err && req_ready, "R1 after reset",
        {ee_cs, ee_sk, resp_valid, resp_err, req_ready}, 5'b00001);
    run_cfg(0, 0, 0, 0);
    run_cfg(0, 1, 1, 0);
    run_cfg(1, 0, 0, 1);
    run_cfg(2, 1, 1, 1);
    run_cfg(2, 0, 1, 0);
    repeat (PROG + 10) @(negedge clk);
    chk(sk_bad == 0, "R11 shift clock idle while deselected", sk_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule